// File: doc/BRIEF.md
# Three-Channel Match Timer with Coherent Snapshot

The block holds a bank of free-running up-counters (three by default) behind a simple synchronous register bus. Each channel has three compare values. When an enabled counter equals one of them, a sticky status flag for that comparator is raised. A per-channel select field can name one comparator as the restart point. When that comparator hits, the counter loads its preload value on the next step instead of incrementing. One global register has one run bit per channel. Status flags drive a per-channel interrupt line through an enable mask, and software clears them with a write-one-to-clear register.

Software cannot safely read a counter while it is moving. Instead it writes a request to the channel's snapshot register. The block copies the counter two clock edges later and holds that copy until the next request. Setting a compare value of all ones and a preload of zero gives a plain full-range wrapping counter.

Address map (word addresses; `c` is the channel):
- `c*16 + k` for k = 0..2: compare value k.
- `c*16 + 3`: preload value.
- `c*16 + 4`: restart select.
- `c*16 + 5`: interrupt enable mask.
- `c*16 + 6`: status, read-only.
- `c*16 + 7`: status clear, write-only, reads 0.
- `c*16 + 8`: snapshot.
- `0x30`: run register.

Top module: `match_timer`

## Requirements
- R1: After reset, every counter, status flag, preload, select field, enable mask, snapshot and the run register read 0, every compare value reads 0xFFFFFFFF, and `irq` is 0.
- R2: Bit n of the run register (address 0x30) makes counter n step once per clock edge while it is 1. While the bit is 0, counter n holds its value.
- R3: On a clock edge where counter n is running and equals its compare value k, status bit k of channel n (address n*16+6, bits 2:0) is set, and it stays set until cleared.
- R4: Restart select (address n*16+4, 2 bits) values 1, 2 and 3 pick comparator 0, 1 and 2. On that comparator's hit, the counter's next value is the preload. Value 0 means no restart.
- R5: With compare 0 at 0xFFFFFFFF, preload 0 and select 1, the count 0xFFFFFFFF is followed by 0.
- R6: Writing 1 to bit 0 of the snapshot register of channel n captures the counter value held just before the second clock edge after the write edge. A read before then returns the previous snapshot, and the copy is held until the next request.
- R7: `irq[n]` is 1 exactly when some status bit of channel n has its enable mask bit (address n*16+5) set.
- R8: Writing 1 to bit k of the clear register (address n*16+7) clears status bit k. A match on the same edge wins, and the bit stays set.
- R9: `rdata` is registered: it shows the addressed register one clock edge after `rd_en` is sampled, and written configuration registers read back their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe; data appears on `rdata` after the edge |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 3 | Per-channel interrupt level |

## Verification
The properties assume that a bus write occupies exactly one sampled edge. They also assume that the clear-register address seen at the ports is the only way status can fall. The counter-step properties are written for channels whose select field is steady across the edge being checked, so the stimulus changes select only while a channel is stopped or at edges whose outcome the bench works out by hand. Writes and reads never overlap, and every stimulus change happens on the falling edge, so each register sees one well-defined command per rising edge.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int NCH  = 3,
  parameter int NCMP = 3,
  parameter int CW   = 32,
  parameter int AW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [NCH-1:0] irq
);
  localparam int SW      = $clog2(NCMP + 1);
  localparam int CHW     = AW - 4;
  localparam int OFF_PRE = NCMP;
  localparam int OFF_SEL = NCMP + 1;
  localparam int OFF_IE  = NCMP + 2;
  localparam int OFF_STS = NCMP + 3;
  localparam int OFF_CLR = NCMP + 4;
  localparam int OFF_SNP = NCMP + 5;

  wire [CHW-1:0] a_ch  = addr[AW-1:4];
  wire [3:0]     a_off = addr[3:0];

  logic [NCH-1:0]                    en;
  logic [NCH-1:0][CW-1:0]            cnt_a, pre_a, snap_a, rv;
  logic [NCH-1:0][NCMP-1:0][CW-1:0]  mat_a;
  logic [NCH-1:0][SW-1:0]            sel_a;
  logic [NCH-1:0][NCMP-1:0]          sts_a, ie_a;
  logic [NCH-1:0]                    pend1_a;

  always_ff @(posedge clk) begin
    if (!rst_n) en <= '0;
    else if (wr_en && a_ch == CHW'(NCH) && a_off == 4'd0) en <= wdata[NCH-1:0];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CW-1:0]   mat [NCMP];
    logic [CW-1:0]   cnt, pre, snap, mrd;
    logic [SW-1:0]   sel;
    logic [NCMP-1:0] ie, sts, hit, rl;
    logic [1:0]      pend;
    wire             wsel = wr_en && a_ch == CHW'(ch);

    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
      assign hit[k] = en[ch] && cnt == mat[k];
      assign rl[k]  = hit[k] && sel == SW'(k + 1);
      assign mat_a[ch][k] = mat[k];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < NCMP; k++) mat[k] <= '1;
        cnt  <= '0;
        pre  <= '0;
        sel  <= '0;
        ie   <= '0;
        sts  <= '0;
        snap <= '0;
        pend <= '0;
      end else begin
        for (int k = 0; k < NCMP; k++)
          if (wsel && a_off == 4'(k)) mat[k] <= wdata;
        if (wsel && a_off == 4'(OFF_PRE)) pre <= wdata;
        if (wsel && a_off == 4'(OFF_SEL)) sel <= wdata[SW-1:0];
        if (wsel && a_off == 4'(OFF_IE))  ie  <= wdata[NCMP-1:0];
        if (en[ch]) cnt <= (|rl) ? pre : cnt + 1'b1;
        sts  <= (sts & ~((wsel && a_off == 4'(OFF_CLR)) ? wdata[NCMP-1:0] : '0)) | hit;
        pend <= {pend[0], wsel && a_off == 4'(OFF_SNP) && wdata[0]};
        if (pend[1]) snap <= cnt;
      end
    end

    always_comb begin
      mrd = '0;
      for (int k = 0; k < NCMP; k++)
        if (a_off == 4'(k)) mrd = mat[k];
    end

    assign rv[ch] = (a_off == 4'(OFF_PRE)) ? pre :
                    (a_off == 4'(OFF_SEL)) ? CW'(sel) :
                    (a_off == 4'(OFF_IE))  ? CW'(ie) :
                    (a_off == 4'(OFF_STS)) ? CW'(sts) :
                    (a_off == 4'(OFF_SNP)) ? snap :
                    mrd;

    assign irq[ch]     = |(sts & ie);
    assign cnt_a[ch]   = cnt;
    assign pre_a[ch]   = pre;
    assign snap_a[ch]  = snap;
    assign sel_a[ch]   = sel;
    assign sts_a[ch]   = sts;
    assign ie_a[ch]    = ie;
    assign pend1_a[ch] = pend[1];
  end

  logic [CW-1:0] rmux;
  always_comb begin
    rmux = '0;
    if (a_ch == CHW'(NCH)) begin
      if (a_off == 4'd0) rmux = CW'(en);
    end else begin
      for (int c = 0; c < NCH; c++)
        if (a_ch == CHW'(c)) rmux = rv[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rmux;
  end
endmodule

module match_timer_chk #(
  parameter int NCH  = 3,
  parameter int NCMP = 3,
  parameter int CW   = 32,
  parameter int AW   = 6,
  parameter int SW   = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic [AW-1:0]                  addr,
  input logic [NCMP-1:0]                wbits,
  input logic [NCH-1:0]                 irq,
  input logic [NCH-1:0]                 en,
  input logic [NCH-1:0][CW-1:0]         cnt_a,
  input logic [NCH-1:0][CW-1:0]         pre_a,
  input logic [NCH-1:0][CW-1:0]         snap_a,
  input logic [NCH-1:0][NCMP-1:0][CW-1:0] mat_a,
  input logic [NCH-1:0][SW-1:0]         sel_a,
  input logic [NCH-1:0][NCMP-1:0]       sts_a,
  input logic [NCH-1:0]                 pend1_a
);
  for (genvar n = 0; n < NCH; n++) begin : g_n
    wire clr_hit = wr_en && addr == AW'(n * 16 + NCMP + 4);

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en[n] |=> $stable(cnt_a[n])); // R2
    AST_STEP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (en[n] && sel_a[n] == '0) |=> cnt_a[n] == $past(cnt_a[n]) + 1'b1); // R2
    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !pend1_a[n] |=> $stable(snap_a[n])); // R6
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq[n] |-> sts_a[n] != '0); // R7

    for (genvar k = 0; k < NCMP; k++) begin : g_k
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_a[n][k] && !(clr_hit && wbits[k])) |=> sts_a[n][k]); // R3
      AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (en[n] && sel_a[n] == SW'(k + 1) && cnt_a[n] == mat_a[n][k])
          |=> cnt_a[n] == $past(pre_a[n])); // R4
    end
  end
endmodule

bind match_timer match_timer_chk #(
  .NCH(NCH), .NCMP(NCMP), .CW(CW), .AW(AW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .wbits(wdata[NCMP-1:0]), .irq(irq), .en(en),
  .cnt_a(cnt_a), .pre_a(pre_a), .snap_a(snap_a), .mat_a(mat_a),
  .sel_a(sel_a), .sts_a(sts_a), .pend1_a(pend1_a)
);

// File: tb/match_timer_tb.sv
module match_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  match_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  localparam logic [5:0] RUN = 6'h30;
  function automatic logic [5:0] ra(input int ch, input int off);
    return 6'(ch * 16 + off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic snap_read(input int ch, output logic [31:0] d);
    wr(ra(ch, 8), 32'd1);
    idle(2);
    rd(ra(ch, 8), d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(RUN, d);        chk("R1 run reg", d, 0);
    rd(ra(0, 6), d);   chk("R1 status ch0", d, 0);
    rd(ra(2, 6), d);   chk("R1 status ch2", d, 0);
    rd(ra(1, 2), d);   chk("R1 compare ch1.2", d, 32'hFFFF_FFFF);
    rd(ra(0, 3), d);   chk("R1 preload ch0", d, 0);
    rd(ra(0, 8), d);   chk("R1 snapshot ch0", d, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_gating();
    logic [31:0] d;
    wr(RUN, 32'h2);
    idle(5);
    wr(RUN, 32'h0);
    wr(ra(1, 8), 32'd1);
    rd(ra(1, 8), d);   chk("R6 snapshot latency keeps old", d, 0);
    idle(1);
    rd(ra(1, 8), d);   chk("R2 gated count", d, 6);
    idle(4);
    snap_read(1, d);   chk("R2 stopped counter holds", d, 6);
  endtask

  task automatic t_snap_running();
    logic [31:0] d;
    wr(RUN, 32'h2);
    wr(ra(1, 8), 32'd1);
    idle(2);
    rd(ra(1, 8), d);   chk("R6 running capture", d, 8);
    idle(5);
    rd(ra(1, 8), d);   chk("R6 copy held", d, 8);
    wr(RUN, 32'h0);
  endtask

  task automatic t_reload();
    logic [31:0] d;
    wr(ra(0, 0), 32'd4);
    wr(ra(0, 3), 32'd1);
    wr(ra(0, 4), 32'd1);
    rd(ra(0, 4), d);   chk("R9 select readback", d, 1);
    rd(ra(0, 0), d);   chk("R9 compare readback", d, 4);
    wr(RUN, 32'h1);
    idle(9);
    wr(RUN, 32'h0);
    snap_read(0, d);   chk("R4 restart via comparator 0", d, 2);
    rd(ra(0, 6), d);   chk("R3 status ch0", d, 3'b001);
    chk("R7 masked irq", 32'(irq), 0);
  endtask

  task automatic t_irq_clear();
    logic [31:0] d;
    wr(ra(0, 5), 32'd1);
    chk("R7 irq raised", 32'(irq), 3'b001);
    wr(ra(0, 7), 32'd1);
    rd(ra(0, 6), d);   chk("R8 clear", d, 0);
    chk("R7 irq dropped", 32'(irq), 0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(ra(0, 4), 32'd0);
    wr(ra(0, 0), 32'd2);
    wr(RUN, 32'h1);
    wr(ra(0, 7), 32'd1);
    wr(RUN, 32'h0);
    rd(ra(0, 6), d);   chk("R8 match beats clear", d, 3'b001);
    wr(ra(0, 7), 32'd1);
    rd(ra(0, 6), d);   chk("R8 later clear", d, 0);
    snap_read(0, d);   chk("R4 select 0 no restart", d, 4);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(ra(2, 1), 32'd0);
    wr(ra(2, 2), 32'd5);
    wr(ra(2, 3), 32'hFFFF_FFFD);
    wr(ra(2, 4), 32'd2);
    wr(RUN, 32'h4);
    wr(ra(2, 4), 32'd1);
    wr(ra(2, 3), 32'd0);
    idle(3);
    wr(RUN, 32'h0);
    snap_read(2, d);   chk("R5 full-range wrap", d, 2);
    rd(ra(2, 6), d);   chk("R3 R4 status ch2", d, 3'b011);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_gating();
    t_snap_running();
    t_reload();
    t_irq_clear();
    t_priority();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end
endmodule